// File: doc/BRIEF.md
# Decode Serialization Gate

This block sits at the head of the decode stage and makes instructions that need serializing run strictly in program order. Instructions arrive one at a time as a valid/ready stream. Each arriving head carries a flag that marks it as serializing. Ordinary instructions pass whenever the in-flight window has room. A serializing instruction is held at the head until every older instruction has retired. It is then let through on its own. Nothing younger is accepted until that instruction has retired as well.

The block counts instructions between dispatch and retirement. The count goes up on each accepted head and goes down by the number of retirements reported in a cycle. A flush empties the count and returns the gate to normal flow. The retirement logic itself lives outside this block; the block only sees a per-cycle retire count.

Stream rules: an instruction is transferred in a cycle where `head_valid` and `head_ready` are both high. The producer must hold the head and its flag stable while `head_valid` is high and `head_ready` is low. `head_ready` may depend on `head_valid` and `head_serial` in the same cycle.

Top module: `ser_gate`

## Requirements
- R1: After reset, the gate is in normal flow with an empty window: `dec_enable`=1, `single_issue`=0, `pipe_idle`=1, and `head_ready` follows R2.
- R2: In normal flow, with no flush, a valid head whose `head_serial` is 0 sees `head_ready`=1 while fewer than MAX_INFLIGHT instructions are in flight.
- R3: The in-flight count rises by one on each transfer and falls by `retire_cnt` in the same cycle. It saturates at zero when retirements exceed the count. `pipe_idle` is 1 exactly when the count is zero.
- R4: While MAX_INFLIGHT instructions are in flight, `head_ready` is 0.
- R5: In normal flow, a head with `head_serial`=1 sees `head_ready`=0. On the next cycle the gate enters the older-drain phase if the count is nonzero, or the single-issue phase if it is zero.
- R6: In the older-drain phase, `dec_enable` and `head_ready` are 0. On the cycle after the count is seen as zero, the gate enters the single-issue phase.
- R7: In the single-issue phase, `single_issue`=1, `dec_enable`=1 and `head_ready`=1. Exactly one instruction is accepted. On the cycle after that transfer, `dec_enable` is 0.
- R8: In the serial-drain phase, `dec_enable` and `head_ready` are 0 until the serializing instruction has retired and the count is zero. On the cycle after that, the gate is back in normal flow.
- R9: During a cycle with `flush`=1, `dec_enable` and `head_ready` are 0. On the next cycle the gate is in normal flow with a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; empties the window and restarts flow |
| head_valid | input | 1 | Decode head holds an instruction |
| head_serial | input | 1 | Head instruction requires serialization |
| head_ready | output | 1 | Head instruction is accepted this cycle |
| retire_cnt | input | $clog2(RET_MAX+1) | Instructions retired this cycle |
| dec_enable | output | 1 | Decode stage is allowed to advance |
| single_issue | output | 1 | Only the serializing instruction may pass |
| pipe_idle | output | 1 | No instruction is in flight |

## Verification
Random streams with rare serializing heads show that ordinary traffic flows unhindered between serializations. Random retire counts, some larger than the count, exercise the saturating counter. A directed fill to capacity with no retirements separates back-pressure from a full window from back-pressure caused by serialization. Directed serializing heads, arriving once with older work pending and once with an empty window, tell apart the path through the drain phase and the direct path to single issue. Flushes injected in each phase show that every state returns to normal flow with an empty count.

// File: rtl/ser_gate_pkg.sv
package ser_gate_pkg;
  typedef enum logic [1:0] {
    SG_FLOW      = 2'd0,
    SG_WAIT_OLD  = 2'd1,
    SG_SOLO      = 2'd2,
    SG_WAIT_SOLO = 2'd3
  } sg_state_e;
endpackage

// File: rtl/ser_inflight_cnt.sv
module ser_inflight_cnt #(
  parameter int MAX_INFLIGHT = 16,
  parameter int RET_MAX      = 4,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1),
  localparam int RET_W = $clog2(RET_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             inc,
  input  logic [RET_W-1:0] dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             idle,
  output logic             full
);
  localparam int SUM_W = (CNT_W > RET_W ? CNT_W : RET_W) + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] dec_ext;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    sum     = SUM_W'(cnt_q) + SUM_W'(inc);
    dec_ext = SUM_W'(dec);
    if (flush || dec_ext >= sum) cnt_d = '0;
    else                          cnt_d = CNT_W'(sum - dec_ext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idle = (cnt_q == '0);
  assign full = (cnt_q >= CNT_W'(MAX_INFLIGHT));
endmodule

// File: rtl/ser_fsm.sv
module ser_fsm
  import ser_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      head_valid,
  input  logic      head_serial,
  input  logic      fire,
  input  logic      idle,
  output sg_state_e state_q,
  output logic      dec_enable,
  output logic      single_issue
);
  sg_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SG_FLOW:      if (head_valid && head_serial) state_d = idle ? SG_SOLO : SG_WAIT_OLD;
      SG_WAIT_OLD:  if (idle) state_d = SG_SOLO;
      SG_SOLO:      if (fire) state_d = SG_WAIT_SOLO;
      SG_WAIT_SOLO: if (idle) state_d = SG_FLOW;
      default:      state_d = SG_FLOW;
    endcase
    if (flush) state_d = SG_FLOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SG_FLOW;
    else        state_q <= state_d;
  end

  assign dec_enable   = !flush && (state_q == SG_FLOW || state_q == SG_SOLO);
  assign single_issue = (state_q == SG_SOLO);
endmodule

// File: rtl/ser_gate.sv
module ser_gate
  import ser_gate_pkg::*;
#(
  parameter int MAX_INFLIGHT = 16,
  parameter int RET_MAX      = 4,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1),
  localparam int RET_W = $clog2(RET_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             head_valid,
  input  logic             head_serial,
  output logic             head_ready,
  input  logic [RET_W-1:0] retire_cnt,
  output logic             dec_enable,
  output logic             single_issue,
  output logic             pipe_idle
);
  sg_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             fire;

  assign head_ready = dec_enable && !full && (single_issue || !head_serial);
  assign fire       = head_valid && head_ready;

  ser_inflight_cnt #(.MAX_INFLIGHT(MAX_INFLIGHT), .RET_MAX(RET_MAX)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .inc   (fire),
    .dec   (retire_cnt),
    .cnt_q (cnt_q),
    .idle  (pipe_idle),
    .full  (full)
  );

  ser_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .head_valid   (head_valid),
    .head_serial  (head_serial),
    .fire         (fire),
    .idle         (pipe_idle),
    .state_q      (state_q),
    .dec_enable   (dec_enable),
    .single_issue (single_issue)
  );
endmodule

// File: rtl/ser_gate_chk.sv
module ser_gate_chk
  import ser_gate_pkg::*;
#(
  parameter int MAX_INFLIGHT = 16,
  parameter int RET_MAX      = 4,
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1),
  localparam int RET_W = $clog2(RET_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             head_valid,
  input logic             head_serial,
  input logic             head_ready,
  input logic [RET_W-1:0] retire_cnt,
  input logic             dec_enable,
  input logic             single_issue,
  input logic             pipe_idle,
  input logic [CNT_W-1:0] cnt_q,
  input sg_state_e        state_q
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_INFLIGHT)); // R4
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(MAX_INFLIGHT)) |-> !head_ready); // R4
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && head_ready && retire_cnt == '0 && !flush) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_SERIAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && head_serial && !single_issue) |-> !head_ready); // R5
  AST_DISABLED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_enable |-> !head_ready); // R6
  AST_ONE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    (single_issue && head_valid && head_ready && !flush) |=> !dec_enable); // R7
  AST_SOLO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SG_WAIT_SOLO && pipe_idle && !flush) |=> state_q == SG_FLOW); // R8
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pipe_idle && !single_issue)); // R9
endmodule

bind ser_gate ser_gate_chk #(.MAX_INFLIGHT(MAX_INFLIGHT), .RET_MAX(RET_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .head_valid   (head_valid),
  .head_serial  (head_serial),
  .head_ready   (head_ready),
  .retire_cnt   (retire_cnt),
  .dec_enable   (dec_enable),
  .single_issue (single_issue),
  .pipe_idle    (pipe_idle),
  .cnt_q        (cnt_q),
  .state_q      (state_q)
);

// File: tb/test_ser_gate.sv
`timescale 1ns/1ps
module test_ser_gate;
  localparam int MAXF = 16;
  localparam int RMAX = 4;
  localparam int RW   = $clog2(RMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, head_valid = 1'b0, head_serial = 1'b0;
  logic [RW-1:0] retire_cnt = '0;
  logic head_ready, dec_enable, single_issue, pipe_idle;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int m_st = 0;   // 0 flow, 1 wait old, 2 solo, 3 wait solo
  int m_cnt = 0;

  always #4 clk = ~clk;

  ser_gate #(.MAX_INFLIGHT(MAXF), .RET_MAX(RMAX)) i_ser_gate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .head_valid(head_valid),
    .head_serial(head_serial), .head_ready(head_ready), .retire_cnt(retire_cnt),
    .dec_enable(dec_enable), .single_issue(single_issue), .pipe_idle(pipe_idle)
  );

  function automatic bit exp_en();
    return !flush && (m_st == 0 || m_st == 2);
  endfunction

  function automatic bit exp_ready();
    return exp_en() && (m_cnt < MAXF) && (m_st == 2 || !head_serial);
  endfunction

  function automatic string tag_ready();
    if (flush) return "R9";
    case (m_st)
      0: return (m_cnt >= MAXF) ? "R4" : (head_serial ? "R5" : "R2");
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit fl, input bit hv, input bit hs, input int rc);
    bit f;
    int s;
    @(negedge clk);
    flush = fl; head_valid = hv; head_serial = hs; retire_cnt = RW'(rc);
    #2;
    chk(tag_ready(), "head_ready", head_ready, exp_ready());
    chk(flush ? "R9" : (m_st == 1 ? "R6" : (m_st == 3 ? "R8" : "R7")), "dec_enable", dec_enable, exp_en());
    chk("R7", "single_issue", single_issue, m_st == 2);
    chk("R3", "pipe_idle", pipe_idle, m_cnt == 0);
    f = hv && exp_ready();
    @(posedge clk);
    s = m_st;
    case (m_st)
      0: if (hv && hs) s = (m_cnt == 0) ? 2 : 1;
      1: if (m_cnt == 0) s = 2;
      2: if (f) s = 3;
      default: if (m_cnt == 0) s = 0;
    endcase
    if (fl) s = 0;
    m_st = s;
    if (fl || (m_cnt + int'(f)) <= rc) m_cnt = 0;
    else m_cnt = m_cnt + int'(f) - rc;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk("R1", "reset dec_enable", dec_enable, 1);
    chk("R1", "reset single_issue", single_issue, 0);
    chk("R1", "reset pipe_idle", pipe_idle, 1);
    rst_n = 1'b1;
    // R4: fill to capacity, then try one more
    for (int i = 0; i < MAXF + 3; i++) step(0, 1, 0, 0);
    // R5/R6: serializing head with older work pending, drain slowly
    for (int i = 0; i < 6; i++) step(0, 1, 1, 3);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1);
    // R8: hold retire until serial drains
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 1);
    step(0, 1, 0, 0);
    // R5 direct path with empty window
    for (int i = 0; i < 3; i++) step(0, 0, 0, 4);
    step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    // R3 clamp: retire more than in flight
    step(0, 0, 0, 4);
    step(0, 1, 0, 7);
    // R9 flush in drain phase
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(1, 1, 1, 0);
    step(0, 1, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit hv, hs, fl;
      int rc;
      hv = ($urandom_range(0, 9) < 7);
      hs = ($urandom_range(0, 19) == 0);
      fl = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 29) == 0) rc = $urandom_range(0, (1 << RW) - 1);
      else rc = $urandom_range(0, (m_cnt < RMAX) ? m_cnt : RMAX);
      step(fl, hv, hs, rc);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule